// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Generator

This block is the bus-facing half of a small processor whose external bus shares sixteen lines between address and data and carries a 20-bit address. An internal core hands it one transfer at a time: a read, a write or an interrupt-acknowledge, with the target address, the write data, a two-bit segment code, a flag for high-byte transfer and the current interrupt-enable flag. The block then runs a four-clock bus cycle (T1 to T4), stretching it with wait states while the external ready line is low, and returns read data together with a one-clock completion pulse.

During T1 the whole address appears on the pins with the address-latch strobe high. From T2 on, the low lines carry data and the four upper lines carry status: the segment code, the interrupt flag and a low bus-owned bit. The block also sequences the read, write and acknowledge strobes, the memory/IO select, the high-byte enable, the transfer direction and the buffer enable. An external master can take the bus with a hold request. The running cycle is finished first. Then the block raises hold-acknowledge and drops the output enables that model the floating pins.

Top module: `mbus_cycle_gen`

## Requirements
- R1: While and after synchronous reset, the block is idle: `cyc_idle`=1, `ale`=0, `rd_n`=`wr_n`=`inta_n`=`den_n`=1, `dt_r`=`mio`=`bhe_n`=1, `ad_oe`=`up_oe`=0, `ctl_oe`=1, `hlda`=0, `done`=0.
- R2: A request is taken on a rising edge where `cyc_idle`=1, `hold`=0 and `req_valid`=1 (`req_kind` 00 read, 01 write, 10 interrupt acknowledge, 11 treated as read). The clock after that edge is T1, and `ale` is high in T1 only.
- R3: In T1, `ad_out` carries address bits 15:0 with `ad_oe`=1 and `up_oe`=1. `up_out` carries address bits 19:16 for memory cycles. For I/O and acknowledge cycles, the two top bits of `up_out` are 0.
- R4: From T2 through T4, `up_out` = {0, interrupt flag, segment code}. The segment code is passed through unchanged (00 extra, 01 stack, 10 code or none, 11 data). The flag is the value captured when the request was taken.
- R5: `bhe_n` is low in T1 exactly when the request asks for a high-byte transfer. From T2 through T4 it reads 1.
- R6: From T1 through T4, `mio` is 1 for memory cycles and 0 for I/O cycles. It is always 0 for acknowledge cycles, whatever `req_io` is. Over the same clocks `dt_r` is 1 for writes and 0 for reads and acknowledges. `den_n` is low from T2 through T4.
- R7: The strobe for the cycle's kind (`rd_n`, `wr_n` or `inta_n`) is low in T2, T3 and every wait state, and high in T1 and T4. At most one strobe is low at a time. A write drives the write data with `ad_oe`=1 from T2 through T4. Reads and acknowledges hold `ad_oe`=0 from T2 on.
- R8: `ready` is sampled on the edge that ends T3 and on the edge that ends each wait state. Each low sample adds one wait state in which all strobes and status keep their T3 values. With W low samples, T4 falls W+4 clocks after the accepting edge.
- R9: `done` is high for exactly one clock, in T4. For reads and acknowledges, `rdata` then holds the `ad_in` value sampled on the edge that ended the cycle. `cyc_idle` returns to 1 in the clock after T4.
- R10: A `hold` seen while idle wins over a pending request. From the next clock `hlda`=1 and `ad_oe`, `up_oe`, `ctl_oe` are 0, and no cycle starts. One clock after `hold` drops, `hlda`=0 and `ctl_oe`=1. A still-pending request then starts T1 one clock later.
- R11: A `hold` raised during a cycle does not disturb it. The cycle completes with its `done` pulse, and `hlda` rises in the clock after T4.
- R12: While a cycle runs, `cyc_idle` is 0 and a held `req_valid` starts nothing. With `req_valid` held high and no waits, successive T1 clocks are five clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Core requests a bus cycle |
| req_kind | input | 2 | 00 read, 01 write, 10 interrupt acknowledge |
| req_io | input | 1 | 1 selects I/O space, 0 memory |
| req_addr | input | 20 | Cycle address |
| req_wdata | input | 16 | Write data |
| req_seg | input | 2 | Segment code for status |
| req_hi | input | 1 | Transfer uses the high data byte |
| core_if | input | 1 | Interrupt-enable flag for status |
| cyc_idle | output | 1 | Block can take a request |
| done | output | 1 | One-clock completion pulse in T4 |
| rdata | output | 16 | Data captured at end of the cycle |
| ready | input | 1 | External ready; low inserts wait states |
| hold | input | 1 | External master requests the bus |
| hlda | output | 1 | Bus handed over |
| ad_in | input | 16 | Value read from the shared lines |
| ad_out | output | 16 | Value driven onto the shared lines |
| ad_oe | output | 1 | Shared lines driven |
| up_out | output | 4 | Upper address / status lines |
| up_oe | output | 1 | Upper lines driven |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| inta_n | output | 1 | Interrupt acknowledge strobe, active low |
| mio | output | 1 | 1 memory, 0 I/O |
| bhe_n | output | 1 | High-byte enable, active low (status 1 after T1) |
| dt_r | output | 1 | 1 transmit, 0 receive |
| den_n | output | 1 | Data buffer enable, active low |
| ctl_oe | output | 1 | Control strobes driven |

## Verification
Every pin is registered from the next phase, so a pin shows a phase in the same clock the sequencer sits in it. T1 is visible one clock after the accepting edge, T2 two clocks after, T3 three, each wait state one more, and T4 plus `done` and `rdata` W+4 clocks after. Hold effects show one clock after the edge that sees `hold`. The bench drives inputs and samples on the falling edge. It walks a phase counter of its own alongside the design and sets `ready` in T3 and in each wait state for the edge that follows. It compares every pin in every clock of every cycle against values it derives from the request fields.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  localparam int unsigned MB_DW = 16;
  localparam int unsigned MB_AW = 20;
  localparam int unsigned MB_UW = MB_AW - MB_DW;
  localparam int unsigned MB_SW = 2;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_TW   = 3'd4,
    PH_T4   = 3'd5,
    PH_HOLD = 3'd6
  } phase_e;

  typedef enum logic [1:0] {
    CK_READ  = 2'd0,
    CK_WRITE = 2'd1,
    CK_INTA  = 2'd2
  } kind_e;

  typedef struct packed {
    kind_e            kind;
    logic             io;
    logic [MB_AW-1:0] addr;
    logic [MB_DW-1:0] wdata;
    logic [MB_SW-1:0] seg;
    logic             hi;
    logic             ifl;
  } cyc_t;

endpackage

// File: rtl/mbus_seq.sv
module mbus_seq
  import mbus_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   req_valid,
  input  cyc_t   req_in,
  input  logic   ready,
  input  logic   hold,
  output phase_e ph_d,
  output cyc_t   cyc_d,
  output logic   cap_en,
  output logic   idle
);

  phase_e ph_q;
  cyc_t   cyc_q;
  logic   accept;

  assign accept = (ph_q == PH_IDLE) && !hold && req_valid;
  assign cyc_d  = accept ? req_in : cyc_q;
  assign cap_en = ((ph_q == PH_T3) || (ph_q == PH_TW)) && ready;
  assign idle   = (ph_q == PH_IDLE);

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE: begin
        if (hold)           ph_d = PH_HOLD;
        else if (req_valid) ph_d = PH_T1;
      end
      PH_T1:   ph_d = PH_T2;
      PH_T2:   ph_d = PH_T3;
      PH_T3,
      PH_TW:   ph_d = ready ? PH_T4 : PH_TW;
      PH_T4:   ph_d = hold ? PH_HOLD : PH_IDLE;
      PH_HOLD: ph_d = hold ? PH_HOLD : PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= PH_IDLE;
      cyc_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cyc_q <= cyc_d;
    end
  end

endmodule

// File: rtl/mbus_pins.sv
module mbus_pins
  import mbus_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  phase_e           ph_d,
  input  cyc_t             cyc_d,
  output logic [MB_DW-1:0] ad_out,
  output logic             ad_oe,
  output logic [MB_UW-1:0] up_out,
  output logic             up_oe,
  output logic             ale,
  output logic             rd_n,
  output logic             wr_n,
  output logic             inta_n,
  output logic             mio,
  output logic             bhe_n,
  output logic             dt_r,
  output logic             den_n,
  output logic             ctl_oe,
  output logic             hlda
);

  logic t1, mid, late, act;
  logic is_rd, is_wr, is_ia, is_io;
  logic [MB_UW-1:0] t1_up, st_up;

  assign t1    = (ph_d == PH_T1);
  assign mid   = (ph_d == PH_T2) || (ph_d == PH_T3) || (ph_d == PH_TW);
  assign late  = mid || (ph_d == PH_T4);
  assign act   = t1 || late;
  assign is_rd = (cyc_d.kind == CK_READ);
  assign is_wr = (cyc_d.kind == CK_WRITE);
  assign is_ia = (cyc_d.kind == CK_INTA);
  assign is_io = cyc_d.io || is_ia;

  // Upper lines: address in T1, status afterwards.
  for (genvar g = 0; g < MB_UW; g++) begin : g_up
    if (g < MB_SW) begin : g_seg
      assign t1_up[g] = cyc_d.addr[MB_DW+g];
      assign st_up[g] = cyc_d.seg[g];
    end else begin : g_top
      assign t1_up[g] = cyc_d.addr[MB_DW+g] & ~is_io;
      assign st_up[g] = (g == MB_UW - 2) ? cyc_d.ifl : 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ad_out <= '0;
      ad_oe  <= 1'b0;
      up_out <= '0;
      up_oe  <= 1'b0;
      ale    <= 1'b0;
      rd_n   <= 1'b1;
      wr_n   <= 1'b1;
      inta_n <= 1'b1;
      mio    <= 1'b1;
      bhe_n  <= 1'b1;
      dt_r   <= 1'b1;
      den_n  <= 1'b1;
      ctl_oe <= 1'b1;
      hlda   <= 1'b0;
    end else begin
      ale    <= t1;
      ad_oe  <= t1 || (late && is_wr);
      ad_out <= t1 ? cyc_d.addr[MB_DW-1:0] :
                (late && is_wr) ? cyc_d.wdata : '0;
      up_oe  <= act;
      up_out <= t1 ? t1_up : (late ? st_up : '0);
      rd_n   <= !(mid && is_rd);
      wr_n   <= !(mid && is_wr);
      inta_n <= !(mid && is_ia);
      mio    <= act ? !is_io : 1'b1;
      bhe_n  <= !(t1 && cyc_d.hi);
      dt_r   <= act ? is_wr : 1'b1;
      den_n  <= !late;
      ctl_oe <= (ph_d != PH_HOLD);
      hlda   <= (ph_d == PH_HOLD);
    end
  end

endmodule

// File: rtl/mbus_rdcap.sv
module mbus_rdcap
  import mbus_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_en,
  input  phase_e           ph_d,
  input  logic [MB_DW-1:0] ad_in,
  output logic [MB_DW-1:0] rdata,
  output logic             done
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      done  <= 1'b0;
    end else begin
      done <= (ph_d == PH_T4);
      if (cap_en) rdata <= ad_in;
    end
  end

endmodule

// File: rtl/mbus_cycle_gen.sv
module mbus_cycle_gen
  import mbus_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [1:0]       req_kind,
  input  logic             req_io,
  input  logic [MB_AW-1:0] req_addr,
  input  logic [MB_DW-1:0] req_wdata,
  input  logic [MB_SW-1:0] req_seg,
  input  logic             req_hi,
  input  logic             core_if,
  output logic             cyc_idle,
  output logic             done,
  output logic [MB_DW-1:0] rdata,
  input  logic             ready,
  input  logic             hold,
  output logic             hlda,
  input  logic [MB_DW-1:0] ad_in,
  output logic [MB_DW-1:0] ad_out,
  output logic             ad_oe,
  output logic [MB_UW-1:0] up_out,
  output logic             up_oe,
  output logic             ale,
  output logic             rd_n,
  output logic             wr_n,
  output logic             inta_n,
  output logic             mio,
  output logic             bhe_n,
  output logic             dt_r,
  output logic             den_n,
  output logic             ctl_oe
);

  cyc_t   req_pk;
  cyc_t   cyc_d;
  phase_e ph_d;
  logic   cap_en;

  always_comb begin
    req_pk       = '0;
    req_pk.kind  = (req_kind == 2'd1) ? CK_WRITE :
                   (req_kind == 2'd2) ? CK_INTA  : CK_READ;
    req_pk.io    = req_io;
    req_pk.addr  = req_addr;
    req_pk.wdata = req_wdata;
    req_pk.seg   = req_seg;
    req_pk.hi    = req_hi;
    req_pk.ifl   = core_if;
  end

  mbus_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_in    (req_pk),
    .ready     (ready),
    .hold      (hold),
    .ph_d      (ph_d),
    .cyc_d     (cyc_d),
    .cap_en    (cap_en),
    .idle      (cyc_idle)
  );

  mbus_pins u_pins (
    .clk    (clk),
    .rst    (rst),
    .ph_d   (ph_d),
    .cyc_d  (cyc_d),
    .ad_out (ad_out),
    .ad_oe  (ad_oe),
    .up_out (up_out),
    .up_oe  (up_oe),
    .ale    (ale),
    .rd_n   (rd_n),
    .wr_n   (wr_n),
    .inta_n (inta_n),
    .mio    (mio),
    .bhe_n  (bhe_n),
    .dt_r   (dt_r),
    .den_n  (den_n),
    .ctl_oe (ctl_oe),
    .hlda   (hlda)
  );

  mbus_rdcap u_rdcap (
    .clk    (clk),
    .rst    (rst),
    .cap_en (cap_en),
    .ph_d   (ph_d),
    .ad_in  (ad_in),
    .rdata  (rdata),
    .done   (done)
  );

endmodule

// File: rtl/mbus_cycle_gen_chk.sv
module mbus_cycle_gen_chk
  import mbus_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             hold,
  input logic             ready,
  input logic             cyc_idle,
  input logic             done,
  input logic             hlda,
  input logic             ad_oe,
  input logic [MB_UW-1:0] up_out,
  input logic             up_oe,
  input logic             ale,
  input logic             rd_n,
  input logic             wr_n,
  input logic             inta_n,
  input logic             bhe_n,
  input logic             ctl_oe
);

  // R2
  ale_one_clk_chk: assert property (@(posedge clk) disable iff (rst)
    ale |=> !ale);

  // R2
  accept_start_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_idle && req_valid && !hold) |=> ale);

  // R3
  t1_driven_chk: assert property (@(posedge clk) disable iff (rst)
    ale |-> (ad_oe && up_oe && ctl_oe));

  // R4
  bus_owned_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ale) |-> !up_out[MB_UW-1]);

  // R5
  bhe_status_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ale) |-> bhe_n);

  // R7
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({~rd_n, ~wr_n, ~inta_n}) <= 1);

  // R8
  wait_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (!(rd_n && wr_n && inta_n) && !ready) |=> $stable({rd_n, wr_n, inta_n}));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  float_chk: assert property (@(posedge clk) disable iff (rst)
    hlda |-> (!ad_oe && !up_oe && !ctl_oe));

  // R12
  busy_chk: assert property (@(posedge clk) disable iff (rst)
    ale |-> !cyc_idle);

endmodule

bind mbus_cycle_gen mbus_cycle_gen_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .hold      (hold),
  .ready     (ready),
  .cyc_idle  (cyc_idle),
  .done      (done),
  .hlda      (hlda),
  .ad_oe     (ad_oe),
  .up_out    (up_out),
  .up_oe     (up_oe),
  .ale       (ale),
  .rd_n      (rd_n),
  .wr_n      (wr_n),
  .inta_n    (inta_n),
  .bhe_n     (bhe_n),
  .ctl_oe    (ctl_oe)
);

// File: tb/mbus_cycle_gen_tb.sv
module mbus_cycle_gen_tb;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'd0;
  logic        req_io = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_seg = '0;
  logic        req_hi = 1'b0;
  logic        core_if = 1'b0;
  logic        ready = 1'b1;
  logic        hold = 1'b0;
  logic [15:0] ad_in = '0;
  logic        cyc_idle, done, hlda, ad_oe, up_oe, ale;
  logic        rd_n, wr_n, inta_n, mio, bhe_n, dt_r, den_n, ctl_oe;
  logic [15:0] rdata, ad_out;
  logic [3:0]  up_out;

  int nchk = 0;
  int errs = 0;

  always #(CLK_P/2) clk = ~clk;

  mbus_cycle_gen u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_io(req_io), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_seg(req_seg), .req_hi(req_hi), .core_if(core_if),
    .cyc_idle(cyc_idle), .done(done), .rdata(rdata), .ready(ready),
    .hold(hold), .hlda(hlda), .ad_in(ad_in), .ad_out(ad_out),
    .ad_oe(ad_oe), .up_out(up_out), .up_oe(up_oe), .ale(ale),
    .rd_n(rd_n), .wr_n(wr_n), .inta_n(inta_n), .mio(mio),
    .bhe_n(bhe_n), .dt_r(dt_r), .den_n(den_n), .ctl_oe(ctl_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk({tag, " R1 cyc_idle"}, cyc_idle, 1);
    chk({tag, " R1 ale"}, ale, 0);
    chk({tag, " R1 rd_n"}, rd_n, 1);
    chk({tag, " R1 wr_n"}, wr_n, 1);
    chk({tag, " R1 inta_n"}, inta_n, 1);
    chk({tag, " R1 den_n"}, den_n, 1);
    chk({tag, " R1 dt_r"}, dt_r, 1);
    chk({tag, " R1 mio"}, mio, 1);
    chk({tag, " R1 bhe_n"}, bhe_n, 1);
    chk({tag, " R1 ad_oe"}, ad_oe, 0);
    chk({tag, " R1 up_oe"}, up_oe, 0);
    chk({tag, " R1 ctl_oe"}, ctl_oe, 1);
    chk({tag, " R1 hlda"}, hlda, 0);
    chk({tag, " R1 done"}, done, 0);
  endtask

  // ph: 1 = T1, 2 = T2, 3 = T3 or wait state, 4 = T4
  task automatic chk_phase(input string tag, input int ph, input int k, input bit io,
                           input logic [19:0] a, input logic [15:0] wd,
                           input logic [1:0] sg, input bit hi, input bit ifl);
    bit io_eff = io || (k == 2);
    logic [3:0] up_exp;
    logic [15:0] ad_exp;
    up_exp = (ph == 1) ? (io_eff ? {2'b00, a[17:16]} : a[19:16]) : {1'b0, ifl, sg};
    ad_exp = (ph == 1) ? a[15:0] : ((k == 1) ? wd : 16'h0);
    chk({tag, " R2 ale"}, ale, (ph == 1));
    chk({tag, " R12 cyc_idle"}, cyc_idle, 0);
    chk({tag, " R3 ad_oe"}, ad_oe, (ph == 1) || (k == 1));
    chk({tag, " R3 ad_out"}, ad_out, ad_exp);
    chk({tag, " R3 up_oe"}, up_oe, 1);
    chk({tag, " R4 up_out"}, up_out, up_exp);
    chk({tag, " R5 bhe_n"}, bhe_n, (ph == 1) ? !hi : 1'b1);
    chk({tag, " R6 mio"}, mio, !io_eff);
    chk({tag, " R6 dt_r"}, dt_r, (k == 1));
    chk({tag, " R6 den_n"}, den_n, (ph == 1));
    chk({tag, " R7 rd_n"}, rd_n, !((k == 0) && (ph == 2 || ph == 3)));
    chk({tag, " R7 wr_n"}, wr_n, !((k == 1) && (ph == 2 || ph == 3)));
    chk({tag, " R7 inta_n"}, inta_n, !((k == 2) && (ph == 2 || ph == 3)));
    chk({tag, " R9 done"}, done, (ph == 4));
    chk({tag, " R10 hlda"}, hlda, 0);
    chk({tag, " R10 ctl_oe"}, ctl_oe, 1);
  endtask

  task automatic run_cycle(input int k, input bit io, input logic [19:0] a,
                           input logic [15:0] wd, input logic [1:0] sg,
                           input bit hi, input bit ifl, input int waits,
                           input logic [15:0] rv);
    req_kind = 2'(k); req_io = io; req_addr = a; req_wdata = wd;
    req_seg = sg; req_hi = hi; core_if = ifl; ad_in = rv; ready = 1'b1;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    core_if = ~ifl;
    req_seg = ~sg;
    chk_phase("T1", 1, k, io, a, wd, sg, hi, ifl);
    @(negedge clk);
    chk_phase("T2", 2, k, io, a, wd, sg, hi, ifl);
    @(negedge clk);
    chk_phase("T3", 3, k, io, a, wd, sg, hi, ifl);
    ready = (waits == 0);
    for (int w = 0; w < waits; w++) begin
      @(negedge clk);
      chk_phase("R8 wait", 3, k, io, a, wd, sg, hi, ifl);
      ready = (w == waits - 1);
    end
    @(negedge clk);
    chk_phase("R8 T4", 4, k, io, a, wd, sg, hi, ifl);
    if (k != 1) chk("R9 rdata", rdata, rv);
    ready = 1'b1;
    ad_in = ~rv;
    @(negedge clk);
    chk_idle("R9 after");
  endtask

  initial begin
    #(CLK_P * 150000);
    errs++;
    nchk++;
    $display("FAIL watchdog act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end

  initial begin
    int idx = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk_idle("R1 in reset");
    rst = 1'b0;
    @(negedge clk);
    chk_idle("R1 after reset");

    // Sweep kinds, spaces, segments, byte lanes, flag and wait counts
    for (int k = 0; k < 3; k++)
      for (int io = 0; io < 2; io++)
        for (int sg = 0; sg < 4; sg++)
          for (int hi = 0; hi < 2; hi++)
            for (int fl = 0; fl < 2; fl++)
              for (int w = 0; w < 3; w++) begin
                logic [19:0] a = 20'(idx * 32'h1B3D7 + 32'h5A5);
                logic [15:0] wd = 16'(idx * 32'h3C5 + 1);
                run_cycle(k, io[0], a, wd, 2'(sg), hi[0], fl[0], w, ~wd);
                idx++;
              end

    // R10: hold while idle with a pending request
    req_kind = 2'd0; req_io = 1'b0; req_addr = 20'hABCDE; req_seg = 2'd3;
    req_hi = 1'b0; core_if = 1'b1; ad_in = 16'h1234; ready = 1'b1;
    hold = 1'b1; req_valid = 1'b1;
    @(negedge clk);
    chk("R10 hlda", hlda, 1);
    chk("R10 ad_oe", ad_oe, 0);
    chk("R10 up_oe", up_oe, 0);
    chk("R10 ctl_oe", ctl_oe, 0);
    chk("R10 ale", ale, 0);
    @(negedge clk);
    chk("R10 still held", hlda, 1);
    chk("R10 request ignored ale", ale, 0);
    chk("R10 request ignored cyc_idle", cyc_idle, 0);
    hold = 1'b0;
    @(negedge clk);
    chk("R10 release hlda", hlda, 0);
    chk("R10 release ctl_oe", ctl_oe, 1);
    chk("R10 release ale", ale, 0);
    chk("R10 release cyc_idle", cyc_idle, 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 pending ale", ale, 1);
    chk("R10 pending up_out", up_out, 4'hA);
    chk("R10 pending ad_out", ad_out, 16'hBCDE);
    repeat (3) @(negedge clk);
    chk("R10 pending done", done, 1);
    chk("R10 pending rdata", rdata, 16'h1234);
    @(negedge clk);
    chk_idle("R10 end");

    // R11: hold raised mid-cycle, one wait state
    req_kind = 2'd0; req_addr = 20'h12345; ad_in = 16'h0F0F; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 T1 ale", ale, 1);
    @(negedge clk);
    hold = 1'b1;
    @(negedge clk);
    chk("R11 T3 rd_n", rd_n, 0);
    chk("R11 T3 hlda", hlda, 0);
    chk("R11 T3 ctl_oe", ctl_oe, 1);
    ready = 1'b0;
    @(negedge clk);
    chk("R11 wait rd_n", rd_n, 0);
    chk("R11 wait done", done, 0);
    ready = 1'b1;
    @(negedge clk);
    chk("R11 T4 done", done, 1);
    chk("R11 T4 hlda", hlda, 0);
    chk("R11 T4 rdata", rdata, 16'h0F0F);
    @(negedge clk);
    chk("R11 after hlda", hlda, 1);
    chk("R11 after ctl_oe", ctl_oe, 0);
    hold = 1'b0;
    @(negedge clk);
    chk_idle("R11 end");

    // R12: request held high across back-to-back cycles
    req_kind = 2'd1; req_wdata = 16'hBEEF; req_valid = 1'b1; ready = 1'b1;
    for (int i = 1; i <= 9; i++) begin
      @(negedge clk);
      chk($sformatf("R12 ale clk%0d", i), ale, (i == 1 || i == 6));
      chk($sformatf("R12 cyc_idle clk%0d", i), cyc_idle, (i == 5));
      if (i == 9) req_valid = 1'b0;
    end
    @(negedge clk);
    chk_idle("R12 end");

    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end

endmodule